// File: doc/BRIEF.md
# DRAM Refresh Request Sequencer

This block sits on the user side of a DRAM controller whose automatic refresh has been switched off. It drives the controller's register master port: address, write, read, write data, read data, read-data-valid and a waitrequest handshake. Once after reset it writes 1 to the controller's user-refresh-enable register. After that it serves refresh requests that a refresh timer or a traffic-aware scheduler raises on a simple valid/ready interface with a per-rank mask.

For each accepted request the sequencer first writes the rank mask to the refresh-request register. It then keeps the bus quiet for a fixed number of cycles and reads the acknowledge field. If the acknowledge is clear, it waits the same interval again and re-reads. When the acknowledge is seen, it gives a one-cycle `done` pulse. If the acknowledge is still clear after the permitted number of re-reads, it raises a sticky `timeout_err`. In both cases it returns to idle and takes the next request.

Register addresses, the acknowledge bit position, the rank count, the wait interval and the retry limit are all parameters.

Top module: `refresh_sequencer`

## Requirements
- R1: After reset the bus is idle for one cycle. The first access is then a single write of value 1 to `EN_ADDR` (default 0x10). No write to `REQ_ADDR` happens before that write has completed, and it is never repeated.
- R2: Each accepted request produces exactly one write to `REQ_ADDR` (default 0x14). Its data carries the request's rank mask in bits [NUM_RANKS-1:0], with bit i selecting rank i, and zeros above.
- R3: A completed request write is followed by exactly `WAIT_CYCLES` (32) cycles with both strobes low. The read of `ACK_ADDR` (default 0x18) is asserted in the cycle that follows.
- R4: If the returned word has bit `ACK_BIT` (default 8) set when `mm_readdatavalid` is high, `done` is high for exactly the next cycle. `req_ready` is high in that same cycle.
- R5: While `mm_waitrequest` is high, an asserted strobe, `mm_address` and `mm_writedata` hold their values. An access completes in the first cycle its strobe is high with `mm_waitrequest` low. Read and write are never asserted together.
- R6: If the acknowledge bit reads clear, the read is repeated after another `WAIT_CYCLES` quiet cycles. If `MAX_RETRIES` (default 4) re-reads all return it clear, `timeout_err` is set, no `done` is given, and the block returns to idle.
- R7: `timeout_err` stays set until the next request is accepted, and it clears in the cycle after acceptance.
- R8: `req_ready` is high only when no access or wait is in progress, and both strobes are low whenever `req_ready` is high. A request held high while the block is busy is accepted later with its mask, not dropped.
- R9: Bits of `mm_readdata` other than `ACK_BIT` have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Refresh request from the scheduler |
| req_rank_mask | input | NUM_RANKS | Ranks to refresh, one bit per rank |
| req_ready | output | 1 | Sequencer idle; request accepted when both are high |
| done | output | 1 | One-cycle pulse when the acknowledge is seen |
| timeout_err | output | 1 | Sticky: acknowledge never seen within the retry limit |
| mm_address | output | ADDR_W | Register address |
| mm_write | output | 1 | Write strobe |
| mm_read | output | 1 | Read strobe |
| mm_writedata | output | DATA_W | Write data |
| mm_readdata | input | DATA_W | Read data |
| mm_readdatavalid | input | 1 | Read data valid |
| mm_waitrequest | input | 1 | Controller not clear to accept the access |

## Verification
The bench model of the controller acknowledges either on the first read, after a chosen number of reads, or never. Single-read, multi-retry and timeout runs therefore each exercise a different exit from the polling loop. Each of these is run once with `mm_waitrequest` held low and once with a pseudo-random stall pattern. The stall pattern separates correct hold-until-accepted behaviour from a sequencer that counts its wait from the strobe rather than from completion. The returned word carries noise in its other bits, which exposes a decode of the wrong acknowledge bit. A request held high across a busy period checks that it is deferred, not lost. The request after a timeout checks that the error clears.

// File: rtl/refresh_seq_pkg.sv
package refresh_seq_pkg;

  typedef enum logic [2:0] {
    ST_BOOT     = 3'd0,
    ST_ENABLE   = 3'd1,
    ST_IDLE     = 3'd2,
    ST_REQ_WR   = 3'd3,
    ST_GAP      = 3'd4,
    ST_ACK_RD   = 3'd5,
    ST_ACK_DATA = 3'd6
  } seq_state_t;

endpackage

// File: rtl/rf_gap_timer.sv
// Counts the quiet interval between a completed access and the next poll.
module rf_gap_timer #(
  parameter int CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic count_en,
  output logic expired
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = CNT_W'(CYCLES - 1);
    else if (count_en && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load || count_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rf_retry_counter.sv
// Counts acknowledge re-reads for one request.
module rf_retry_counter #(
  parameter int MAX_RETRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic at_limit
);
  localparam int RW = $clog2(MAX_RETRIES + 1);

  logic [RW-1:0] tries_q, tries_d;

  always_comb begin
    tries_d = tries_q;
    if (clear)     tries_d = '0;
    else if (bump) tries_d = tries_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tries_q <= '0;
    else if (clear || bump) tries_q <= tries_d;
  end

  assign at_limit = (tries_q == RW'(MAX_RETRIES));
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_RANKS   = 4,
  parameter int EN_ADDR     = 'h10,
  parameter int REQ_ADDR    = 'h14,
  parameter int ACK_ADDR    = 'h18,
  parameter int ACK_BIT     = 8,
  parameter int WAIT_CYCLES = 32,
  parameter int MAX_RETRIES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [NUM_RANKS-1:0] req_rank_mask,
  output logic                 req_ready,
  output logic                 done,
  output logic                 timeout_err,
  output logic [ADDR_W-1:0]    mm_address,
  output logic                 mm_write,
  output logic                 mm_read,
  output logic [DATA_W-1:0]    mm_writedata,
  input  logic [DATA_W-1:0]    mm_readdata,
  input  logic                 mm_readdatavalid,
  input  logic                 mm_waitrequest
);
  import refresh_seq_pkg::*;

  localparam logic [DATA_W-1:0] ACK_MASK = DATA_W'(1) << ACK_BIT;

  seq_state_t           state_q, state_d;
  logic [NUM_RANKS-1:0] mask_q;
  logic                 done_q, err_q;
  logic                 accept, wr_done, rd_done, ack_hit;
  logic                 done_set, err_set, gap_load, retry_bump, gap_over, retry_full;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign wr_done = mm_write && !mm_waitrequest;
  assign rd_done = mm_read && !mm_waitrequest;
  assign ack_hit = |(mm_readdata & ACK_MASK);

  rf_gap_timer #(.CYCLES(WAIT_CYCLES)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .count_en (state_q == ST_GAP),
    .expired  (gap_over)
  );

  rf_retry_counter #(.MAX_RETRIES(MAX_RETRIES)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .bump     (retry_bump),
    .at_limit (retry_full)
  );

  always_comb begin
    state_d    = state_q;
    done_set   = 1'b0;
    err_set    = 1'b0;
    gap_load   = 1'b0;
    retry_bump = 1'b0;
    case (state_q)
      ST_BOOT:   state_d = ST_ENABLE;
      ST_ENABLE: if (wr_done) state_d = ST_IDLE;
      ST_IDLE:   if (accept) state_d = ST_REQ_WR;
      ST_REQ_WR: if (wr_done) begin
        state_d  = ST_GAP;
        gap_load = 1'b1;
      end
      ST_GAP:    if (gap_over) state_d = ST_ACK_RD;
      ST_ACK_RD: if (rd_done) state_d = ST_ACK_DATA;
      ST_ACK_DATA: if (mm_readdatavalid) begin
        if (ack_hit) begin
          done_set = 1'b1;
          state_d  = ST_IDLE;
        end else if (retry_full) begin
          err_set  = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          retry_bump = 1'b1;
          gap_load   = 1'b1;
          state_d    = ST_GAP;
        end
      end
      default:   state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_set;
      if (accept)       err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (accept) mask_q <= req_rank_mask;
  end

  always_comb begin
    mm_write     = 1'b0;
    mm_read      = 1'b0;
    mm_address   = '0;
    mm_writedata = '0;
    case (state_q)
      ST_ENABLE: begin
        mm_write     = 1'b1;
        mm_address   = ADDR_W'(EN_ADDR);
        mm_writedata = DATA_W'(1);
      end
      ST_REQ_WR: begin
        mm_write     = 1'b1;
        mm_address   = ADDR_W'(REQ_ADDR);
        mm_writedata = DATA_W'(mask_q);
      end
      ST_ACK_RD: begin
        mm_read    = 1'b1;
        mm_address = ADDR_W'(ACK_ADDR);
      end
      default: ;
    endcase
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;
endmodule

// File: rtl/refresh_sequencer_chk.sv
module refresh_sequencer_chk #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int EN_ADDR     = 'h10,
  parameter int REQ_ADDR    = 'h14,
  parameter int WAIT_CYCLES = 32,
  parameter int ACK_BIT     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mm_write,
  input logic              mm_read,
  input logic [ADDR_W-1:0] mm_address,
  input logic [DATA_W-1:0] mm_writedata,
  input logic [DATA_W-1:0] mm_readdata,
  input logic              mm_readdatavalid,
  input logic              mm_waitrequest,
  input logic              req_ready,
  input logic              done
);
  localparam logic [DATA_W-1:0] ACK_MASK = DATA_W'(1) << ACK_BIT;

  logic        en_seen;
  logic [15:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_seen <= 1'b0;
      gap     <= '0;
    end else begin
      if (mm_write && !mm_waitrequest && mm_address == ADDR_W'(EN_ADDR)) en_seen <= 1'b1;
      if ((mm_write && !mm_waitrequest && mm_address == ADDR_W'(REQ_ADDR)) ||
          (mm_readdatavalid && !(|(mm_readdata & ACK_MASK))))
        gap <= '0;
      else if (gap != 16'hFFFF)
        gap <= gap + 1'b1;
    end
  end

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_write && mm_waitrequest) |=> (mm_write && $stable(mm_address) && $stable(mm_writedata))); // R5
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_read && mm_waitrequest) |=> (mm_read && $stable(mm_address))); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_write && mm_read)); // R5
  AST_REQ_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_write && mm_address == ADDR_W'(REQ_ADDR)) |-> en_seen); // R1
  AST_POLL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mm_read) |-> (gap == 16'(WAIT_CYCLES))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mm_write && !mm_read)); // R8
endmodule

bind refresh_sequencer refresh_sequencer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_ADDR(EN_ADDR), .REQ_ADDR(REQ_ADDR),
  .WAIT_CYCLES(WAIT_CYCLES), .ACK_BIT(ACK_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mm_write(mm_write), .mm_read(mm_read),
  .mm_address(mm_address), .mm_writedata(mm_writedata), .mm_readdata(mm_readdata),
  .mm_readdatavalid(mm_readdatavalid), .mm_waitrequest(mm_waitrequest),
  .req_ready(req_ready), .done(done)
);

// File: tb/refresh_sequencer_test.sv
module refresh_sequencer_test;
  localparam int NR = 4;
  localparam int GAP = 32;
  localparam int MAXR = 4;
  localparam int ABIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [NR-1:0] req_rank_mask = '0;
  logic req_ready, done, timeout_err, mm_write, mm_read;
  logic [7:0] mm_address;
  logic [31:0] mm_writedata;
  logic [31:0] mm_readdata;
  logic mm_readdatavalid, mm_waitrequest;

  always #10 clk = ~clk;

  refresh_sequencer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rank_mask(req_rank_mask),
    .req_ready(req_ready), .done(done), .timeout_err(timeout_err),
    .mm_address(mm_address), .mm_write(mm_write), .mm_read(mm_read),
    .mm_writedata(mm_writedata), .mm_readdata(mm_readdata),
    .mm_readdatavalid(mm_readdatavalid), .mm_waitrequest(mm_waitrequest)
  );

  int vectors = 0;
  int fails = 0;

  // ---------------- controller stand-in ----------------
  int   stall_mode = 0;
  int   ack_plan = 0;
  int   reads_left;
  int   en_count;
  logic [7:0] lfsr;
  logic p1_v, p2_v;
  logic [31:0] p1_d, p2_d;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= 8'h5A; mm_waitrequest <= 1'b0; reads_left <= 0; en_count <= 0;
      p1_v <= 1'b0; p2_v <= 1'b0; p1_d <= '0; p2_d <= '0;
      mm_readdatavalid <= 1'b0; mm_readdata <= '0;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mm_waitrequest <= (stall_mode != 0) && (lfsr[1:0] != 2'b00);
      p1_v <= 1'b0;
      if (mm_write && !mm_waitrequest) begin
        if (mm_address == 8'h10) en_count <= en_count + 1;
        if (mm_address == 8'h14) reads_left <= ack_plan;
      end
      if (mm_read && !mm_waitrequest) begin
        p1_v <= 1'b1;
        // noise in all other bits so a wrong bit decode shows (R9)
        p1_d <= (reads_left == 0) ? (32'h1 << ABIT) : ~(32'h1 << ABIT);
        if (reads_left != 0) reads_left <= reads_left - 1;
      end
      p2_v <= p1_v; p2_d <= p1_d;
      mm_readdatavalid <= p2_v;
      mm_readdata <= p2_v ? p2_d : 32'hDEAD_BEEF & ~(32'h1 << ABIT);
    end
  end

  // ---------------- behavioural reference ----------------
  // phases: 0 boot, 1 enable write, 2 idle, 3 request write, 4 gap, 5 poll read, 6 await data
  int ph, gapc, tries;
  logic [NR-1:0] m_mask;
  logic m_done, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; gapc = 0; tries = 0; m_mask = '0; m_done = 1'b0; m_err = 1'b0;
    end else begin
      m_done = 1'b0;
      case (ph)
        0: ph = 1;
        1: if (!mm_waitrequest) ph = 2;
        2: if (req_valid) begin m_mask = req_rank_mask; tries = 0; m_err = 1'b0; ph = 3; end
        3: if (!mm_waitrequest) begin ph = 4; gapc = 0; end
        4: begin gapc++; if (gapc == GAP) ph = 5; end
        5: if (!mm_waitrequest) ph = 6;
        6: if (mm_readdatavalid) begin
             if (mm_readdata[ABIT]) begin m_done = 1'b1; ph = 2; end
             else if (tries == MAXR) begin m_err = 1'b1; ph = 2; end
             else begin tries++; gapc = 0; ph = 4; end
           end
        default: ph = 0;
      endcase
    end
  end

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic ew, er;
    logic [7:0] ea;
    logic [31:0] ed;
    ew = (ph == 1) || (ph == 3);
    er = (ph == 5);
    ea = (ph == 1) ? 8'h10 : (ph == 3) ? 8'h14 : (ph == 5) ? 8'h18 : 8'h00;
    ed = (ph == 1) ? 32'h1 : (ph == 3) ? 32'(m_mask) : 32'h0;
    check(mm_write === ew, "R2", "mm_write", 32'(mm_write), 32'(ew));
    check(mm_read === er, "R3", "mm_read", 32'(mm_read), 32'(er));
    if (ew || er) check(mm_address === ea, "R1", "mm_address", 32'(mm_address), 32'(ea));
    if (ew) check(mm_writedata === ed, "R2", "mm_writedata", mm_writedata, ed);
    check(req_ready === (ph == 2), "R8", "req_ready", 32'(req_ready), 32'(ph == 2));
    check(done === m_done, "R4", "done", 32'(done), 32'(m_done));
    check(timeout_err === m_err, "R6", "timeout_err", 32'(timeout_err), 32'(m_err));
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [NR-1:0] mask, input int plan);
    ack_plan = plan;
    @(negedge clk);
    req_valid = 1'b1; req_rank_mask = mask;
    forever begin
      @(posedge clk);
      if (req_ready) break;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    do begin @(negedge clk); n++; end while (ph != 2 && n < 5000);
    check(ph == 2, "R8", "return to idle", 32'(ph), 32'd2);
  endtask

  task automatic finish_run();
    check(en_count == 1, "R1", "enable writes", 32'(en_count), 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_idle();                              // R1 enable handshake
    issue(4'b0001, 0); wait_idle();           // R2 R3 R4 first-read acknowledge
    stall_mode = 1;
    issue(4'b1010, 2); wait_idle();           // R5 R6 retries under stalls
    issue(4'b1111, 100); wait_idle();         // R6 timeout
    check(timeout_err === 1'b1, "R6", "err set after timeout", 32'(timeout_err), 32'd1);
    stall_mode = 0;
    issue(4'b0100, 0);                        // R7 clears on accept
    check(timeout_err === 1'b0, "R7", "err cleared", 32'(timeout_err), 32'd0);
    // R8: request held high while busy, accepted afterwards
    @(negedge clk);
    req_valid = 1'b1; req_rank_mask = 4'b0110;
    wait_idle();
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();                              // R9 noise bits ignored on every read
    repeat (5) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule